// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block keeps a DRAM subsystem parked after reset until the memory can safely be used. It first holds every strobe inactive for a settling pause. It then generates a fixed burst of wake-up strobe cycles and finally raises a ready flag. That flag releases the access controller and the refresh scheduler that sit beside it. While the sequencer owns the strobes it raises a drive-select output, so that the surrounding logic multiplexes its RAS and CAS onto the memory pins.

The kind of wake-up cycle follows a mode input. When the memory will be refreshed from its own internal row counter, each wake-up cycle drops CAS one clock before RAS. Otherwise only RAS pulses and CAS stays high. Every duration is given in nanoseconds and turned into a clock count at elaboration time, rounded up, from a clock-period parameter in picoseconds.

After ready is raised, the block watches a pulse input that marks every RAS falling edge made by the other memory blocks. If more than the idle limit passes with no such pulse, it drops ready, takes the strobes back and repeats the full burst of wake-up cycles without a new pause. It then raises ready again.

Top module: `dram_wake_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mem_ready_o` is 0, `init_drive_o` is 1, and both `ras_n_o` and `cas_n_o` are 1.
- R2: No RAS low cycle occurs before PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PS) clock cycles have passed since reset was released. The first fall comes at most 4 cycles after that.
- R3: Between reset release (or an idle expiry) and the next rise of `mem_ready_o`, exactly WAKE_CYCLES (default 8) RAS low pulses are produced.
- R4: Every RAS low pulse lasts exactly LOW_CYC = ceil(RAS_LOW_NS*1000/CLK_PS) cycles (3 at 50 MHz with 50 ns).
- R5: Between two wake-up RAS pulses, RAS stays high for at least PRE_CYC = ceil(PRECHG_NS*1000/CLK_PS) cycles (2 at 50 MHz with 30 ns).
- R6: With `refresh_ctr_mode_i` = 1 when a cycle starts, CAS goes low one cycle before RAS falls, stays low for the whole RAS low time and returns high in the same cycle as RAS.
- R7: With `refresh_ctr_mode_i` = 0 when a cycle starts, CAS stays high before, during and after the RAS pulse.
- R8: While `mem_ready_o` is 1, `ras_n_o` and `cas_n_o` are 1 and `init_drive_o` is 0.
- R9: Once ready, the block stays ready as long as `ext_ras_fall_i` pulses arrive with no gap of more than IDLE_CYC = ceil(IDLE_NS*1000/CLK_PS) cycles.
- R10: After IDLE_CYC+1 ready cycles with no `ext_ras_fall_i` pulse, `mem_ready_o` falls and `init_drive_o` rises. This does not happen earlier than that. The first new RAS fall follows within 3 cycles, with no pause, and then the R3 burst runs again.
- R11: `ext_ras_fall_i` pulses during the pause or the wake-up burst have no effect: the pause length and the pulse count stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_ctr_mode_i | input | 1 | 1: CAS-before-RAS wake-up cycles, 0: RAS-only wake-up cycles |
| ext_ras_fall_i | input | 1 | One-cycle pulse per RAS falling edge made by other blocks |
| ras_n_o | output | 1 | RAS strobe from the sequencer, active low |
| cas_n_o | output | 1 | CAS strobe from the sequencer, active low |
| init_drive_o | output | 1 | 1 while the sequencer owns the strobes |
| mem_ready_o | output | 1 | 1 when the memory may be used |

## Verification
The bound checker watches, on every clock, the quiet strobes during ready, the RAS low width, the minimum precharge gap and the CAS lead before RAS. It also checks that no strobe appears before the pause has elapsed, that the number of RAS falls equals the burst size when ready rises, and that an idle expiry drops ready on the next cycle. Some behaviours need a chosen input history and only the bench's scenarios can show them. These are the mode switch between bursts, keep-alive pulses that hold ready, the exact edge of the idle window, the missing pause on re-initialization, and pulses during initialization that are ignored.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [1:0] {
    SQ_PAUSE,
    SQ_WAKE,
    SQ_READY
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CAS_LEAD,
    PH_RAS_LOW,
    PH_PRECHG
  } strobe_ph_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned ps_per_cycle);
    logic [63:0] num;
    num = 64'(ns) * 64'd1000 + 64'(ps_per_cycle) - 64'd1;
    return 32'(num / 64'(ps_per_cycle));
  endfunction

  // counter width able to hold max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    if (max_val < 2) return 1;
    return 32'($clog2(64'(max_val) + 64'd1));
  endfunction

endpackage

// File: rtl/dws_pause_timer.sv
module dws_pause_timer
  import dws_pkg::*;
#(
  parameter int unsigned CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  generate
    if (CYCLES == 0) begin : g_none
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign expired   = run;
    end else begin : g_count
      localparam int unsigned W = cnt_width(CYCLES);
      logic [W-1:0] cnt;

      assign expired = run && (cnt == W'(CYCLES - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (run && !expired) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dws_strobe_gen.sv
module dws_strobe_gen
  import dws_pkg::*;
#(
  parameter int unsigned LOW_CYC = 3,
  parameter int unsigned PRE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cbr,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);

  localparam int unsigned MAXC = (LOW_CYC > PRE_CYC) ? LOW_CYC : PRE_CYC;
  localparam int unsigned W    = cnt_width(MAXC);

  strobe_ph_e   ph, ph_nx;
  logic [W-1:0] cnt, cnt_nx;
  logic         cbr_q;
  logic         last_low, last_pre;

  assign last_low = (cnt == W'(LOW_CYC - 1));
  assign last_pre = (cnt == W'(PRE_CYC - 1));

  always_comb begin
    ph_nx  = ph;
    cnt_nx = cnt;
    case (ph)
      PH_IDLE: begin
        if (start) begin
          ph_nx  = cbr ? PH_CAS_LEAD : PH_RAS_LOW;
          cnt_nx = '0;
        end
      end
      PH_CAS_LEAD: begin
        ph_nx  = PH_RAS_LOW;
        cnt_nx = '0;
      end
      PH_RAS_LOW: begin
        if (last_low) begin
          ph_nx  = PH_PRECHG;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      PH_PRECHG: begin
        if (last_pre) begin
          ph_nx  = PH_IDLE;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: begin
        ph_nx  = PH_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      cbr_q <= 1'b0;
    end else begin
      ph  <= ph_nx;
      cnt <= cnt_nx;
      if (ph == PH_IDLE && start) begin
        cbr_q <= cbr;
      end
    end
  end

  assign ras_n = (ph != PH_RAS_LOW);
  assign cas_n = !(cbr_q && (ph == PH_CAS_LEAD || ph == PH_RAS_LOW));
  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_PRECHG) && last_pre;

endmodule

// File: rtl/dws_idle_watch.sv
module dws_idle_watch
  import dws_pkg::*;
#(
  parameter int unsigned LIMIT = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic kick,
  output logic expired
);

  localparam int unsigned W = cnt_width(LIMIT);
  logic [W-1:0] cnt;

  // fires once LIMIT quiet cycles have already been seen
  assign expired = armed && !kick && (cnt == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!armed || kick) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dram_wake_seq.sv
module dram_wake_seq
  import dws_pkg::*;
#(
  parameter int unsigned CLK_PS      = 20000,
  parameter int unsigned PAUSE_NS    = 200000,
  parameter int unsigned IDLE_NS     = 8000000,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned RAS_LOW_NS  = 50,
  parameter int unsigned PRECHG_NS   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_ctr_mode_i,
  input  logic ext_ras_fall_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_drive_o,
  output logic mem_ready_o
);

  localparam int unsigned PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_PS);
  localparam int unsigned IDLE_CYC  = ns_to_cycles(IDLE_NS, CLK_PS);
  localparam int unsigned LOW_CYC   = ns_to_cycles(RAS_LOW_NS, CLK_PS);
  localparam int unsigned PRE_CYC   = ns_to_cycles(PRECHG_NS, CLK_PS);
  localparam int unsigned WCW       = cnt_width(WAKE_CYCLES);

  seq_state_e     state, state_nx;
  logic [WCW-1:0] wake_cnt;

  // named internal events
  logic pause_done;
  logic cycle_start;
  logic cycle_busy;
  logic cycle_done;
  logic wake_last;
  logic idle_expired;

  dws_pause_timer #(
    .CYCLES (PAUSE_CYC)
  ) u_pause (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == SQ_PAUSE),
    .expired (pause_done)
  );

  assign cycle_start = (state == SQ_WAKE) && !cycle_busy;

  dws_strobe_gen #(
    .LOW_CYC (LOW_CYC),
    .PRE_CYC (PRE_CYC)
  ) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cycle_start),
    .cbr   (refresh_ctr_mode_i),
    .ras_n (ras_n_o),
    .cas_n (cas_n_o),
    .busy  (cycle_busy),
    .done  (cycle_done)
  );

  dws_idle_watch #(
    .LIMIT (IDLE_CYC)
  ) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (state == SQ_READY),
    .kick    (ext_ras_fall_i),
    .expired (idle_expired)
  );

  assign wake_last = cycle_done && (wake_cnt == WCW'(WAKE_CYCLES - 1));

  always_comb begin
    state_nx = state;
    case (state)
      SQ_PAUSE: if (pause_done)   state_nx = SQ_WAKE;
      SQ_WAKE:  if (wake_last)    state_nx = SQ_READY;
      SQ_READY: if (idle_expired) state_nx = SQ_WAKE;
      default:                    state_nx = SQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_PAUSE;
      wake_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state != SQ_WAKE) begin
        wake_cnt <= '0;
      end else if (cycle_done) begin
        wake_cnt <= wake_cnt + 1'b1;
      end
    end
  end

  assign init_drive_o = (state != SQ_READY);
  assign mem_ready_o  = (state == SQ_READY);

endmodule

// File: rtl/dram_wake_seq_chk.sv
module dram_wake_seq_chk
  import dws_pkg::*;
#(
  parameter int unsigned CLK_PS      = 20000,
  parameter int unsigned PAUSE_NS    = 200000,
  parameter int unsigned IDLE_NS     = 8000000,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned RAS_LOW_NS  = 50,
  parameter int unsigned PRECHG_NS   = 30
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic drive,
  input logic ready,
  input logic idle_expired,
  input logic cycle_done
);

  localparam int unsigned PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_PS);
  localparam int unsigned LOW_CYC   = ns_to_cycles(RAS_LOW_NS, CLK_PS);
  localparam int unsigned PRE_CYC   = ns_to_cycles(PRECHG_NS, CLK_PS);

  logic [31:0] since_rst;
  logic [15:0] low_run;
  logic [15:0] high_run;
  logic [15:0] falls;
  logic        ras_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      low_run   <= '0;
      high_run  <= 16'hFFFF;
      falls     <= '0;
      ras_q     <= 1'b1;
    end else begin
      if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1'b1;
      low_run <= ras_n ? 16'd0 : low_run + 1'b1;
      if (!ras_n)                   high_run <= 16'd0;
      else if (high_run != 16'hFFFF) high_run <= high_run + 1'b1;
      if (ready)                    falls <= 16'd0;
      else if (ras_q && !ras_n)     falls <= falls + 1'b1;
      ras_q <= ras_n;
    end
  end

  AST_QUIET_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ras_n && cas_n && !drive)); // R8
  AST_PAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (since_rst >= 32'(PAUSE_CYC))); // R2
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run == 16'(LOW_CYC))); // R4
  AST_PRECHG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_run >= 16'(PRE_CYC))); // R5
  AST_CAS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R6
  AST_CAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n); // R6
  AST_WAKE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (falls == 16'(WAKE_CYCLES))); // R3
  AST_REINIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    idle_expired |=> (!ready && drive)); // R10
  AST_DONE_IN_PRECHG: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (ras_n && drive)); // R5

endmodule

bind dram_wake_seq dram_wake_seq_chk #(
  .CLK_PS      (CLK_PS),
  .PAUSE_NS    (PAUSE_NS),
  .IDLE_NS     (IDLE_NS),
  .WAKE_CYCLES (WAKE_CYCLES),
  .RAS_LOW_NS  (RAS_LOW_NS),
  .PRECHG_NS   (PRECHG_NS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ras_n        (ras_n_o),
  .cas_n        (cas_n_o),
  .drive        (init_drive_o),
  .ready        (mem_ready_o),
  .idle_expired (idle_expired),
  .cycle_done   (cycle_done)
);

// File: tb/test_dram_wake_seq.sv
`timescale 1ns/1ps
module test_dram_wake_seq;

  // bench restatement of the timing: 50 MHz clock, short pause and idle window
  localparam int CLK_PS   = 20000;
  localparam int PAUSE_NS = 2000;
  localparam int IDLE_NS  = 4000;
  localparam int PAUSE_E  = 100;   // 2000 ns / 20 ns
  localparam int IDLE_E   = 200;   // 4000 ns / 20 ns
  localparam int TRAS_E   = 3;     // 50 ns over 20 ns, rounded up
  localparam int TRP_E    = 2;     // 30 ns over 20 ns, rounded up
  localparam int NWAKE_E  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cbr_mode = 1'b1;
  logic ext_fall = 1'b0;
  logic ras_n, cas_n, drive, ready;

  always #10 clk = ~clk;

  dram_wake_seq #(
    .CLK_PS   (CLK_PS),
    .PAUSE_NS (PAUSE_NS),
    .IDLE_NS  (IDLE_NS)
  ) i_dram_wake_seq (
    .clk                (clk),
    .rst_n              (rst_n),
    .refresh_ctr_mode_i (cbr_mode),
    .ext_ras_fall_i     (ext_fall),
    .ras_n_o            (ras_n),
    .cas_n_o            (cas_n),
    .init_drive_o       (drive),
    .mem_ready_o        (ready)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit exp_q[$];   // scoreboard: 1 = CAS-before-RAS pulse expected

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_burst(input bit cbr);
    for (int i = 0; i < NWAKE_E; i++) exp_q.push_back(cbr);
  endtask

  task automatic kick();
    @(negedge clk); ext_fall = 1'b1;
    @(negedge clk); ext_fall = 1'b0;
  endtask

  // monitor
  int  cyc = 0, rel_cyc = 0, drop_cyc = 0;
  int  low_len = 0, hi_len = 0, pulses = 0;
  bit  prev_ras = 1, prev_cas = 1, prev_ready = 0, prev_rst = 0;
  bit  seen_fall = 0, reinit_wait = 0;
  bit  cas_pre = 1, cas_lo_all = 0, cas_hi_all = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; prev_ready = 0;
      seen_fall = 0; pulses = 0; hi_len = 0; prev_rst = 0;
    end else begin
      if (!prev_rst) begin rel_cyc = cyc; prev_rst = 1; end
      if (prev_ras && !ras_n) begin
        if (!seen_fall) begin
          check((cyc - rel_cyc >= PAUSE_E) && (cyc - rel_cyc <= PAUSE_E + 4),
                "R2 pause before first RAS fall", cyc - rel_cyc, PAUSE_E);
          seen_fall = 1;
        end else if (!reinit_wait) begin
          check(hi_len >= TRP_E, "R5 precharge gap", hi_len, TRP_E);
        end
        if (reinit_wait) begin
          check(cyc - drop_cyc <= 3, "R10 re-init starts without pause", cyc - drop_cyc, 3);
          reinit_wait = 0;
        end
        cas_pre = prev_cas; cas_lo_all = !cas_n; cas_hi_all = cas_n; low_len = 1;
      end else if (!ras_n) begin
        low_len++;
        cas_lo_all = cas_lo_all & !cas_n;
        cas_hi_all = cas_hi_all & cas_n;
      end else if (!prev_ras && ras_n) begin
        pulses++; hi_len = 1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected extra RAS pulse", pulses, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(low_len == TRAS_E, "R4 RAS low width", low_len, TRAS_E);
          if (e) check(!cas_pre && cas_lo_all && cas_n, "R6 CAS-before-RAS shape",
                       {cas_pre, cas_lo_all, cas_n}, 3'b011);
          else   check(cas_pre && cas_hi_all && cas_n, "R7 RAS-only keeps CAS high",
                       {cas_pre, cas_hi_all, cas_n}, 3'b111);
        end
      end else begin
        hi_len++;
      end
      if (!prev_ready && ready) begin
        check(pulses == NWAKE_E && exp_q.size() == 0, "R3 R11 pulse count at ready",
              pulses, NWAKE_E);
        pulses = 0;
      end
      if (prev_ready && !ready) begin
        drop_cyc = cyc; reinit_wait = 1;
      end
      prev_ras = ras_n; prev_cas = cas_n; prev_ready = ready;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog expired: actual=hung expected=ready");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!ready && drive && ras_n && cas_n, "R1 state in reset",
          {ready, drive, ras_n, cas_n}, 4'b0111);
    expect_burst(1'b1);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    check(!ready && drive && ras_n && cas_n, "R1 state after release",
          {ready, drive, ras_n, cas_n}, 4'b0111);
    // R11: kicks during the pause and during the burst are ignored
    repeat (30) @(negedge clk);
    kick();
    repeat (85) @(negedge clk);
    kick();
    while (!ready) @(negedge clk);
    check(ras_n && cas_n && !drive, "R8 strobes released at ready",
          {ras_n, cas_n, drive}, 3'b110);

    // R9: keep-alive pulses hold ready
    for (int k = 0; k < 4; k++) begin
      repeat (IDLE_E / 2) @(negedge clk);
      check(ready == 1'b1, "R9 ready held by activity", ready, 1);
      kick();
    end

    // R10: go quiet, switch to RAS-only mode for the repeat burst
    cbr_mode = 1'b0;
    expect_burst(1'b0);
    repeat (IDLE_E - 2) @(negedge clk);
    check(ready == 1'b1, "R10 no early expiry", ready, 1);
    for (int w = 0; w < 6 && ready; w++) @(negedge clk);
    check(ready == 1'b0 && drive == 1'b1, "R10 ready drops after idle window",
          {ready, drive}, 2'b01);
    while (!ready) @(negedge clk);
    check(ras_n && cas_n && !drive, "R8 strobes released after re-init",
          {ras_n, cas_n, drive}, 3'b110);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule